// File: doc/BRIEF.md
# Single-Precision Floating-Point Divider

This block divides one 32-bit IEEE-754 single-precision operand by another. A caller presents the dividend and divisor with a one-cycle `start` pulse while the unit is idle. The unit subtracts the biased exponents and runs a restoring shift-subtract loop over the 24-bit significands. It forms a sticky bit from the final partial remainder, normalizes, rounds under a 2-bit mode input, and then raises `done` for one cycle. The quotient, a 5-bit class/sign code and two exception flags stay on the outputs until the next result replaces them. The remainder is never exposed.

Special operands take a short path that skips the iterative loop. Subnormal inputs are read as signed zeros, and results too small to be normal become signed zeros. Two enable inputs, one for invalid operations and one for divide-by-zero, each stop the class/sign code from being rewritten when its own exception occurs. The quotient and the flags are still written in that case.

Top module: `fp_div_sp`

## Requirements
- R1: For finite normal operands, the result exponent is the difference of the biased exponents plus 127. The significand is the quotient of the two 1.f significands. When that quotient is below 1, it is shifted left one place and the exponent is decremented.
- R2: Rounding follows `rnd_mode`: 00 nearest-even, 01 toward zero, 10 toward +infinity, 11 toward -infinity. A guard bit and a sticky bit decide the rounding, and the sticky bit is set by any nonzero final partial remainder.
- R3: If the rounded exponent reaches 255, the result is infinity under nearest-even mode, and also when the rounding direction points away from zero for that sign. Otherwise the result is the largest finite magnitude 0x7F7FFFFF with the result sign.
- R4: An operand whose exponent field is 0 is treated as a zero of its sign. A rounded exponent of 0 or below gives a signed zero, so no result is ever subnormal.
- R5: A finite nonzero dividend divided by a zero gives infinity with the XOR of the operand signs and sets `flag_zdiv`.
- R6: 0/0, inf/inf and any signalling NaN operand (exponent 255, fraction MSB 0, fraction nonzero) give 0x7FC00000 and set `flag_inv`. A quiet NaN operand gives 0x7FC00000 without `flag_inv`.
- R7: Infinity divided by a finite value or by zero gives a signed infinity with no flag. A finite value divided by infinity, and zero divided by a nonzero finite value, give a signed zero.
- R8: `cls` encodes the result as follows: quiet NaN 10001, -inf 01001, -normal 01000, -zero 10010, +zero 00010, +normal 00100, +inf 00101.
- R9: `cls` keeps its previous value when the result raises `flag_inv` while `inv_en` was 1, or raises `flag_zdiv` while `zdiv_en` was 1, with the enables sampled at start. In every other case `cls` is updated.
- R10: `start` is accepted only when `busy` is low. `done` is high for exactly one cycle per accepted operation. `quo`, `cls` and the flags change only together with `done`.
- R11: After reset, `busy`, `done`, `quo`, `cls`, `flag_inv` and `flag_zdiv` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a division (accepted while idle) |
| op_a | input | 32 | Dividend, single precision |
| op_b | input | 32 | Divisor, single precision |
| rnd_mode | input | 2 | Rounding mode, sampled at start |
| inv_en | input | 1 | Invalid-operation enable, sampled at start |
| zdiv_en | input | 1 | Divide-by-zero enable, sampled at start |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle result strobe |
| quo | output | 32 | Quotient, single precision |
| cls | output | 5 | Class/sign code of the last result |
| flag_inv | output | 1 | Last result was an invalid operation |
| flag_zdiv | output | 1 | Last result was a divide by zero |

## Verification
Some properties are checked by assertions on every cycle: the partial remainder stays below twice the divisor, `done` is a single-cycle strobe, and the outputs move only with `done`. They also check that the two flags are never raised together, that each raised flag comes with infinity or the default NaN, that no subnormal result appears, and that a suppressed update leaves `cls` unchanged. The directed scenarios are the only place the quotient values are shown to be correct. These cover exact quotients, quotients that need rounding in all four modes, overflow and underflow in each mode and sign, flushed subnormal inputs, every special-operand pairing, and a `start` pulse issued while the unit is busy.

// File: rtl/fpdiv_pkg.sv
package fpdiv_pkg;
  localparam int EXP_W   = 8;
  localparam int FRAC_W  = 23;
  localparam int SIG_W   = FRAC_W + 1;
  localparam int WORD_W  = 1 + EXP_W + FRAC_W;
  localparam int QBITS   = SIG_W + 2;
  localparam int EXPI_W  = EXP_W + 2;
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_MAX = (1 << EXP_W) - 1;

  localparam logic [WORD_W-1:0] QNAN_W = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_POS  = 2'b10,
    RM_NEG  = 2'b11
  } rmode_e;

  localparam logic [4:0] CL_QNAN  = 5'b10001;
  localparam logic [4:0] CL_NINF  = 5'b01001;
  localparam logic [4:0] CL_NNORM = 5'b01000;
  localparam logic [4:0] CL_NZERO = 5'b10010;
  localparam logic [4:0] CL_PZERO = 5'b00010;
  localparam logic [4:0] CL_PNORM = 5'b00100;
  localparam logic [4:0] CL_PINF  = 5'b00101;

  typedef struct packed {
    logic             sign;
    logic [EXP_W-1:0] exp;
    logic [SIG_W-1:0] sig;
    logic             zero;
    logic             inf;
    logic             nan;
    logic             snan;
  } opnd_t;

  function automatic logic [4:0] class_of(logic [WORD_W-1:0] w);
    logic             s;
    logic [EXP_W-1:0] e;
    logic             fnz;
    s   = w[WORD_W-1];
    e   = w[WORD_W-2 -: EXP_W];
    fnz = |w[FRAC_W-1:0];
    if (e == EXP_W'(EXP_MAX)) begin
      if (fnz) class_of = CL_QNAN;
      else     class_of = s ? CL_NINF : CL_PINF;
    end else if (e == '0) begin
      class_of = s ? CL_NZERO : CL_PZERO;
    end else begin
      class_of = s ? CL_NNORM : CL_PNORM;
    end
  endfunction
endpackage

// File: rtl/fpdiv_unpack.sv
module fpdiv_unpack
  import fpdiv_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output opnd_t             info
);
  logic [EXP_W-1:0]  e;
  logic [FRAC_W-1:0] f;

  always_comb begin
    e         = word[WORD_W-2 -: EXP_W];
    f         = word[FRAC_W-1:0];
    info.sign = word[WORD_W-1];
    info.exp  = e;
    info.sig  = {1'b1, f};
    info.zero = (e == '0);
    info.inf  = (e == EXP_W'(EXP_MAX)) && (f == '0);
    info.nan  = (e == EXP_W'(EXP_MAX)) && (f != '0);
    info.snan = info.nan && !f[FRAC_W-1];
  end
endmodule

// File: rtl/fpdiv_core.sv
module fpdiv_core #(
  parameter int SIG_W = 24,
  parameter int QBITS = SIG_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [SIG_W-1:0] dvd,
  input  logic [SIG_W-1:0] dsr_in,
  output logic [QBITS-1:0] quo,
  output logic             rem_nz
);
  localparam int REM_W = SIG_W + 1;

  logic [REM_W-1:0] rem_q, rem_d, diff;
  logic [SIG_W-1:0] dsr_q;
  logic [QBITS-1:0] q_q, q_d;
  logic             ge;

  always_comb begin
    ge    = rem_q >= {1'b0, dsr_q};
    diff  = rem_q - {1'b0, dsr_q};
    rem_d = rem_q;
    q_d   = q_q;
    if (load) begin
      rem_d = {1'b0, dvd};
      q_d   = '0;
    end else if (step) begin
      rem_d = (ge ? diff : rem_q) << 1;
      q_d   = {q_q[QBITS-2:0], ge};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      q_q   <= '0;
      dsr_q <= {1'b1, {(SIG_W-1){1'b0}}};
    end else begin
      rem_q <= rem_d;
      q_q   <= q_d;
      if (load) dsr_q <= dsr_in;
    end
  end

  assign quo    = q_q;
  assign rem_nz = |rem_q;

  // R1: partial remainder never reaches twice the divisor
  p_rem_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rem_q < {dsr_q, 1'b0});
endmodule

// File: rtl/fpdiv_round.sv
module fpdiv_round
  import fpdiv_pkg::*;
(
  input  logic [QBITS-1:0]         quo,
  input  logic                     rem_nz,
  input  logic signed [EXPI_W-1:0] exp_pre,
  input  logic                     sign,
  input  logic [1:0]               rmode,
  output logic [WORD_W-1:0]        res
);
  localparam logic signed [EXPI_W-1:0] E_TOP  = EXPI_W'(EXP_MAX);
  localparam logic signed [EXPI_W-1:0] E_ZERO = '0;

  logic                     norm, g, s, inc, carry, big;
  logic [SIG_W-1:0]         mant, mant_r;
  logic [SIG_W:0]           sum;
  logic signed [EXPI_W-1:0] e1, e2;

  always_comb begin
    norm = quo[QBITS-1];
    mant = norm ? quo[QBITS-1:2] : quo[QBITS-2:1];
    g    = norm ? quo[1] : quo[0];
    s    = (norm & quo[0]) | rem_nz;
    e1   = norm ? exp_pre : exp_pre - EXPI_W'(1);
    unique case (rmode_e'(rmode))
      RM_NEAR: inc = g & (s | mant[0]);
      RM_ZERO: inc = 1'b0;
      RM_POS:  inc = ~sign & (g | s);
      RM_NEG:  inc = sign & (g | s);
      default: inc = 1'b0;
    endcase
    sum    = {1'b0, mant} + (SIG_W+1)'(inc);
    carry  = sum[SIG_W];
    mant_r = carry ? sum[SIG_W:1] : sum[SIG_W-1:0];
    e2     = carry ? e1 + EXPI_W'(1) : e1;
    big    = (rmode_e'(rmode) == RM_NEAR) ||
             (rmode_e'(rmode) == RM_POS && !sign) ||
             (rmode_e'(rmode) == RM_NEG && sign);
    if (e2 >= E_TOP) begin
      res = big ? {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}}
                : {sign, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
    end else if (e2 <= E_ZERO) begin
      res = {sign, {(WORD_W-1){1'b0}}};
    end else begin
      res = {sign, e2[EXP_W-1:0], mant_r[FRAC_W-1:0]};
    end
  end
endmodule

// File: rtl/fp_div_sp.sv
module fp_div_sp
  import fpdiv_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] op_a,
  input  logic [31:0] op_b,
  input  logic [1:0]  rnd_mode,
  input  logic        inv_en,
  input  logic        zdiv_en,
  output logic        busy,
  output logic        done,
  output logic [31:0] quo,
  output logic [4:0]  cls,
  output logic        flag_inv,
  output logic        flag_zdiv
);
  localparam int CNT_W = $clog2(QBITS);

  typedef enum logic [1:0] {S_IDLE, S_CALC, S_FIN} st_e;

  logic [1:0] rs_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  st_e st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic accept, fin, step;

  opnd_t ua, ub;
  fpdiv_unpack u_unp_a (.word(op_a), .info(ua));
  fpdiv_unpack u_unp_b (.word(op_b), .info(ub));

  logic              sp_hit, sp_inv, sp_zd, rsign;
  logic [WORD_W-1:0] sp_res;
  logic signed [EXPI_W-1:0] exp_diff;

  always_comb begin
    rsign  = ua.sign ^ ub.sign;
    sp_hit = 1'b1;
    sp_inv = 1'b0;
    sp_zd  = 1'b0;
    sp_res = '0;
    if (ua.nan || ub.nan || (ua.zero && ub.zero) || (ua.inf && ub.inf)) begin
      sp_res = QNAN_W;
      sp_inv = ua.snan | ub.snan | (ua.zero & ub.zero) | (ua.inf & ub.inf);
    end else if (ua.inf) begin
      sp_res = {rsign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else if (ub.zero) begin
      sp_res = {rsign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      sp_zd  = 1'b1;
    end else if (ua.zero || ub.inf) begin
      sp_res = {rsign, {(WORD_W-1){1'b0}}};
    end else begin
      sp_hit = 1'b0;
    end
    exp_diff = EXPI_W'(ua.exp) - EXPI_W'(ub.exp) + EXPI_W'(BIAS);
  end

  assign accept = (st_q == S_IDLE) && start;
  assign step   = (st_q == S_CALC);
  assign fin    = (st_q == S_FIN);

  always_comb begin
    st_d  = st_q;
    cnt_d = '0;
    unique case (st_q)
      S_IDLE: if (start) st_d = sp_hit ? S_FIN : S_CALC;
      S_CALC: begin
        cnt_d = cnt_q + CNT_W'(1);
        if (cnt_q == CNT_W'(QBITS - 1)) st_d = S_FIN;
      end
      S_FIN:   st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  logic                     hit_q, inv_q, zd_q, sign_q, ie_q, ze_q;
  logic [WORD_W-1:0]        spr_q;
  logic signed [EXPI_W-1:0] exp_q;
  logic [1:0]               rm_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      hit_q  <= 1'b0;
      inv_q  <= 1'b0;
      zd_q   <= 1'b0;
      sign_q <= 1'b0;
      ie_q   <= 1'b0;
      ze_q   <= 1'b0;
      spr_q  <= '0;
      exp_q  <= '0;
      rm_q   <= '0;
    end else if (accept) begin
      hit_q  <= sp_hit;
      inv_q  <= sp_inv;
      zd_q   <= sp_zd;
      sign_q <= rsign;
      ie_q   <= inv_en;
      ze_q   <= zdiv_en;
      spr_q  <= sp_res;
      exp_q  <= exp_diff;
      rm_q   <= rnd_mode;
    end
  end

  logic [QBITS-1:0]  qbits;
  logic              rem_nz;
  logic [WORD_W-1:0] rnd_res, res;

  fpdiv_core #(.SIG_W(SIG_W), .QBITS(QBITS)) u_core (
    .clk(clk), .rst_n(rst_int_n), .load(accept), .step(step),
    .dvd(ua.sig), .dsr_in(ub.sig), .quo(qbits), .rem_nz(rem_nz)
  );

  fpdiv_round u_round (
    .quo(qbits), .rem_nz(rem_nz), .exp_pre(exp_q), .sign(sign_q),
    .rmode(rm_q), .res(rnd_res)
  );

  logic supp;
  assign res  = hit_q ? spr_q : rnd_res;
  assign supp = (inv_q & ie_q) | (zd_q & ze_q);

  logic              done_q, finv_q, fzd_q;
  logic [WORD_W-1:0] quo_q;
  logic [4:0]        cls_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      done_q <= 1'b0;
      finv_q <= 1'b0;
      fzd_q  <= 1'b0;
      quo_q  <= '0;
      cls_q  <= '0;
    end else begin
      done_q <= fin;
      if (fin) begin
        quo_q  <= res;
        finv_q <= inv_q;
        fzd_q  <= zd_q;
        if (!supp) cls_q <= class_of(res);
      end
    end
  end

  assign busy      = (st_q != S_IDLE);
  assign done      = done_q;
  assign quo       = quo_q;
  assign cls       = cls_q;
  assign flag_inv  = finv_q;
  assign flag_zdiv = fzd_q;

  // R10: one-cycle strobe, produced only by a busy unit; outputs move only with it
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |=> !done);
  p_done_busy_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |-> $past(busy));
  p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    !$stable(quo) |-> done);
  // R5 / R6: flags are exclusive and come with their fixed results
  p_flag_excl_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(flag_inv && flag_zdiv));
  p_zdiv_inf_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    flag_zdiv |-> quo[30:0] == 31'h7F800000);
  p_inv_qnan_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    flag_inv |-> quo == 32'h7FC00000);
  // R4: a zero exponent field always comes with a zero fraction
  p_no_subnorm_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |-> (quo[30:23] != 8'h00 || quo[22:0] == 23'h0));
  // R9: a suppressed update leaves the class code untouched
  p_cls_keep_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    done && ((flag_inv && ie_q) || (flag_zdiv && ze_q)) |-> $stable(cls));
endmodule

// File: tb/fp_div_sp_tb.sv
module fp_div_sp_tb;
  localparam int CLK_P = 10;

  localparam logic [4:0] K_QNAN  = 5'b10001;
  localparam logic [4:0] K_NINF  = 5'b01001;
  localparam logic [4:0] K_NNORM = 5'b01000;
  localparam logic [4:0] K_NZERO = 5'b10010;
  localparam logic [4:0] K_PZERO = 5'b00010;
  localparam logic [4:0] K_PNORM = 5'b00100;
  localparam logic [4:0] K_PINF  = 5'b00101;

  logic        clk, rst_n, start, inv_en, zdiv_en;
  logic [31:0] op_a, op_b;
  logic [1:0]  rnd_mode;
  logic        busy, done, flag_inv, flag_zdiv;
  logic [31:0] quo;
  logic [4:0]  cls;

  int checks = 0;
  int errors = 0;

  logic [31:0] r_quo;
  logic [4:0]  r_cls;
  logic        r_inv, r_zd;

  fp_div_sp u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .rnd_mode(rnd_mode), .inv_en(inv_en), .zdiv_en(zdiv_en), .busy(busy),
    .done(done), .quo(quo), .cls(cls), .flag_inv(flag_inv), .flag_zdiv(flag_zdiv)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  task automatic div(input logic [31:0] a, input logic [31:0] b, input logic [1:0] rm,
                     input logic ie, input logic ze);
    logic got;
    got = 1'b0;
    @(negedge clk);
    op_a = a; op_b = b; rnd_mode = rm; inv_en = ie; zdiv_en = ze; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 60; i++) begin
      if (done) begin got = 1'b1; break; end
      @(negedge clk);
    end
    chk("R10 done seen", {31'd0, got}, 32'd1);
    r_quo = quo; r_cls = cls; r_inv = flag_inv; r_zd = flag_zdiv;
    @(negedge clk);
    chk("R10 done one cycle", {31'd0, done}, 32'd0);
  endtask

  task automatic expect_res(input string tag, input logic [31:0] eq, input logic [4:0] ec,
                            input logic ei, input logic ez);
    chk({tag, " quo"}, r_quo, eq);
    chk({tag, " cls R8"}, {27'd0, r_cls}, {27'd0, ec});
    chk({tag, " inv"}, {31'd0, r_inv}, {31'd0, ei});
    chk({tag, " zdiv"}, {31'd0, r_zd}, {31'd0, ez});
  endtask

  task automatic t_reset;
    chk("R11 busy", {31'd0, busy}, 32'd0);
    chk("R11 done", {31'd0, done}, 32'd0);
    chk("R11 quo", quo, 32'd0);
    chk("R11 cls", {27'd0, cls}, 32'd0);
    chk("R11 flags", {30'd0, flag_inv, flag_zdiv}, 32'd0);
  endtask

  task automatic t_exact;
    div(32'h40C00000, 32'h40000000, 2'b00, 1'b0, 1'b0);
    expect_res("R1 6/2", 32'h40400000, K_PNORM, 1'b0, 1'b0);
    div(32'h3F800000, 32'h40000000, 2'b01, 1'b0, 1'b0);
    expect_res("R1 1/2", 32'h3F000000, K_PNORM, 1'b0, 1'b0);
    div(32'hC1200000, 32'h40A00000, 2'b00, 1'b0, 1'b0);
    expect_res("R1 -10/5", 32'hC0000000, K_NNORM, 1'b0, 1'b0);
    div(32'h7F7FFFFF, 32'h3F800000, 2'b00, 1'b0, 1'b0);
    expect_res("R1 max/1", 32'h7F7FFFFF, K_PNORM, 1'b0, 1'b0);
    div(32'h00800000, 32'h3F800000, 2'b00, 1'b0, 1'b0);
    expect_res("R4 minnorm/1", 32'h00800000, K_PNORM, 1'b0, 1'b0);
  endtask

  task automatic t_round;
    logic [31:0] ep [4];
    logic [31:0] en [4];
    ep[0] = 32'h3F2AAAAB; ep[1] = 32'h3F2AAAAA; ep[2] = 32'h3F2AAAAB; ep[3] = 32'h3F2AAAAA;
    en[0] = 32'hBF2AAAAB; en[1] = 32'hBF2AAAAA; en[2] = 32'hBF2AAAAA; en[3] = 32'hBF2AAAAB;
    for (int m = 0; m < 4; m++) begin
      div(32'h3F800000, 32'h3FC00000, 2'(m), 1'b0, 1'b0);
      expect_res("R2 1/1.5", ep[m], K_PNORM, 1'b0, 1'b0);
      div(32'hBF800000, 32'h3FC00000, 2'(m), 1'b0, 1'b0);
      expect_res("R2 -1/1.5", en[m], K_NNORM, 1'b0, 1'b0);
    end
    div(32'h3F800000, 32'h40400000, 2'b00, 1'b0, 1'b0);
    expect_res("R2 1/3 near", 32'h3EAAAAAB, K_PNORM, 1'b0, 1'b0);
  endtask

  task automatic t_overflow;
    logic [31:0] ep [4];
    logic [31:0] en [4];
    ep[0] = 32'h7F800000; ep[1] = 32'h7F7FFFFF; ep[2] = 32'h7F800000; ep[3] = 32'h7F7FFFFF;
    en[0] = 32'hFF800000; en[1] = 32'hFF7FFFFF; en[2] = 32'hFF7FFFFF; en[3] = 32'hFF800000;
    for (int m = 0; m < 4; m++) begin
      div(32'h7F000000, 32'h3F000000, 2'(m), 1'b0, 1'b0);
      expect_res("R3 +ovf", ep[m], (ep[m] == 32'h7F800000) ? K_PINF : K_PNORM, 1'b0, 1'b0);
      div(32'hFF000000, 32'h3F000000, 2'(m), 1'b0, 1'b0);
      expect_res("R3 -ovf", en[m], (en[m] == 32'hFF800000) ? K_NINF : K_NNORM, 1'b0, 1'b0);
    end
  endtask

  task automatic t_underflow;
    div(32'h00800000, 32'h40000000, 2'b10, 1'b0, 1'b0);
    expect_res("R4 +unf", 32'h00000000, K_PZERO, 1'b0, 1'b0);
    div(32'h00800000, 32'hC0000000, 2'b00, 1'b0, 1'b0);
    expect_res("R4 -unf", 32'h80000000, K_NZERO, 1'b0, 1'b0);
    div(32'h00000001, 32'h3F800000, 2'b00, 1'b0, 1'b0);
    expect_res("R4 subnormal dividend", 32'h00000000, K_PZERO, 1'b0, 1'b0);
    div(32'h3F800000, 32'h80000001, 2'b00, 1'b0, 1'b0);
    expect_res("R4 R5 subnormal divisor", 32'hFF800000, K_NINF, 1'b0, 1'b1);
  endtask

  task automatic t_specials;
    for (int m = 0; m < 4; m++) begin
      div(32'h3F800000, 32'h00000000, 2'(m), 1'b0, 1'b0);
      expect_res("R5 1/0", 32'h7F800000, K_PINF, 1'b0, 1'b1);
      div(32'h3F800000, 32'h80000000, 2'(m), 1'b0, 1'b0);
      expect_res("R5 1/-0", 32'hFF800000, K_NINF, 1'b0, 1'b1);
      div(32'h00000000, 32'h00000000, 2'(m), 1'b0, 1'b0);
      expect_res("R6 0/0", 32'h7FC00000, K_QNAN, 1'b1, 1'b0);
      div(32'hFF800000, 32'h7F800000, 2'(m), 1'b0, 1'b0);
      expect_res("R6 inf/inf", 32'h7FC00000, K_QNAN, 1'b1, 1'b0);
      div(32'h7F800001, 32'h3F800000, 2'(m), 1'b0, 1'b0);
      expect_res("R6 snan", 32'h7FC00000, K_QNAN, 1'b1, 1'b0);
      div(32'h3F800000, 32'hFFC00001, 2'(m), 1'b0, 1'b0);
      expect_res("R6 qnan", 32'h7FC00000, K_QNAN, 1'b0, 1'b0);
      div(32'hFF800000, 32'h40000000, 2'(m), 1'b0, 1'b0);
      expect_res("R7 -inf/2", 32'hFF800000, K_NINF, 1'b0, 1'b0);
      div(32'h7F800000, 32'h80000000, 2'(m), 1'b0, 1'b0);
      expect_res("R7 inf/-0", 32'hFF800000, K_NINF, 1'b0, 1'b0);
      div(32'h40000000, 32'hFF800000, 2'(m), 1'b0, 1'b0);
      expect_res("R7 2/-inf", 32'h80000000, K_NZERO, 1'b0, 1'b0);
      div(32'h80000000, 32'h40000000, 2'(m), 1'b0, 1'b0);
      expect_res("R7 -0/2", 32'h80000000, K_NZERO, 1'b0, 1'b0);
      div(32'h00000000, 32'h7F800000, 2'(m), 1'b0, 1'b0);
      expect_res("R7 0/inf", 32'h00000000, K_PZERO, 1'b0, 1'b0);
    end
  endtask

  task automatic t_suppress;
    div(32'h40C00000, 32'h40000000, 2'b00, 1'b1, 1'b1);
    expect_res("R9 setup", 32'h40400000, K_PNORM, 1'b0, 1'b0);
    div(32'h00000000, 32'h00000000, 2'b00, 1'b1, 1'b0);
    expect_res("R9 inv suppressed", 32'h7FC00000, K_PNORM, 1'b1, 1'b0);
    div(32'h3F800000, 32'h00000000, 2'b00, 1'b0, 1'b1);
    expect_res("R9 zdiv suppressed", 32'h7F800000, K_PNORM, 1'b0, 1'b1);
    div(32'h3F800000, 32'h00000000, 2'b00, 1'b1, 1'b0);
    expect_res("R9 zdiv with inv_en only", 32'h7F800000, K_PINF, 1'b0, 1'b1);
    div(32'h00000000, 32'h00000000, 2'b00, 1'b0, 1'b1);
    expect_res("R9 inv with zdiv_en only", 32'h7FC00000, K_QNAN, 1'b1, 1'b0);
  endtask

  task automatic t_busy_start;
    int extra;
    logic got;
    got = 1'b0;
    extra = 0;
    @(negedge clk);
    op_a = 32'h40C00000; op_b = 32'h40000000; rnd_mode = 2'b00;
    inv_en = 1'b0; zdiv_en = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 busy after start", {31'd0, busy}, 32'd1);
    repeat (3) @(negedge clk);
    op_a = 32'h00000000; op_b = 32'h00000000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 60; i++) begin
      if (done) begin got = 1'b1; break; end
      @(negedge clk);
    end
    chk("R10 busy-start result", quo, 32'h40400000);
    chk("R10 busy-start flag", {31'd0, flag_inv}, 32'd0);
    chk("R10 busy-start done", {31'd0, got}, 32'd1);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (done) extra++;
    end
    chk("R10 no second result", 32'(extra), 32'd0);
    chk("R10 idle after", {31'd0, busy}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; op_a = '0; op_b = '0;
    rnd_mode = 2'b00; inv_en = 1'b0; zdiv_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_exact;
    t_round;
    t_overflow;
    t_underflow;
    t_specials;
    t_suppress;
    t_busy_start;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule